// File: doc/BRIEF.md
# Clock Power-Mode Sequencer

This block steps a system between three clock power modes. In full-speed operation the CPU and bus clocks come from a PLL. In direct-run they come from the plain system clock. In halt that system clock is gated off, and only always-on low-frequency logic keeps running. Halt and full-speed operation are never adjacent: every move between them passes through direct-run. The PLL is switched on, switched off or reconfigured only while the system is in direct-run.

A suspend request taken while the system runs at full speed starts the entry sequence. First DRAM is placed in self-refresh, and the block waits for the memory side to acknowledge. Then the clock source moves to the system clock, the current PLL configuration is saved and the PLL is switched off, and the system clock is gated. An enabled wake event in halt ungates the clock and restores the saved PLL configuration, and the block waits for PLL lock. It then returns the clock source to the PLL and releases self-refresh, waiting for the acknowledge to drop.

Each wait for an acknowledge is timed. If a wait lasts too long, a sticky error flag is raised and the wait continues. A separate output, which tells the memory side to stop its self-refresh clock automatically, is set once after reset and then stays set.

Top module: `clk_pwr_seq`

## Requirements
- R1: While reset is asserted: modeOut is 00, clkSelPll is 1, pllEn is 1, pllCfg equals the parameter PLL_RST_CFG, sysclkGate is 0, srReq is 0, errTimeout is 0 and srClkAutoOff is 0.
- R2: suspendReq is acted on only when the block is idle in full-speed operation. Wake inputs are ignored in every mode except halt (modeOut 10).
- R3: modeOut uses 00 for full speed, 01 for direct-run and 10 for halt. After an accepted suspend, srReq rises on the next cycle while modeOut stays 00 and clkSelPll stays 1. Only in the cycle after srAck is sampled high do modeOut become 01 and clkSelPll become 0.
- R4: One cycle after direct-run is entered, the current pllCfg is saved. On the following cycle pllEn goes to 0 and pllCfg goes to 0.
- R5: When pllEn drops, modeOut becomes 10 and sysclkGate becomes 1 in the same cycle. Both hold until a wake bit is high together with its matching wakeEn bit.
- R6: In the cycle after an enabled wake is sampled, modeOut is 01 and sysclkGate is 0. One cycle later pllEn is 1 and pllCfg equals the value saved on entry.
- R7: modeOut returns to 00 with clkSelPll 1 and srReq 0 only in the cycle after pllLock is sampled high. The block is idle again in the cycle after srAck is sampled low.
- R8: pllEn and pllCfg change only on clock edges at which modeOut was 01.
- R9: modeOut never takes the value 11, and it never moves directly between 00 and 10.
- R10: errTimeout rises after TMO_CYCLES consecutive sampled cycles spent waiting for srAck, pllLock or the fall of srAck. It stays high until reset, and the sequence continues once the awaited value arrives.
- R11: srClkAutoOff is 1 from the first clock edge after reset is released, and stays 1.
- R12: srReq is 1 whenever modeOut is not 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| suspendReq | input | 1 | Request to enter halt |
| wakeEvt | input | WAKE_W | Wake event lines |
| wakeEn | input | WAKE_W | Per-line wake enables |
| srAck | input | 1 | DRAM self-refresh acknowledge |
| pllLock | input | 1 | PLL lock indication |
| clkSelPll | output | 1 | Clock source: 1 PLL, 0 system clock |
| pllEn | output | 1 | PLL enable |
| pllCfg | output | CFG_W | PLL configuration word |
| sysclkGate | output | 1 | 1 gates the system clock off |
| srReq | output | 1 | DRAM self-refresh request |
| srClkAutoOff | output | 1 | Auto-stop of self-refresh clock, set once |
| modeOut | output | 2 | Current mode: 00 full speed, 01 direct-run, 10 halt |
| errTimeout | output | 1 | Sticky acknowledge timeout flag |

## Verification
The hardest state to reach from the ports is a handshake that never completes, followed by a normal recovery. The bench's DRAM model can be told to stop answering, which holds srReq unacknowledged past the timeout. It then answers late, and the bench runs the whole suspend and resume round trip with the flag set. The halt mode is also probed with a suspend request and with wake lines whose enables are off, before the enabled wake is applied.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    S_RUN     = 3'd0,
    S_SR_IN   = 3'd1,
    S_SAVE    = 3'd2,
    S_PLL_OFF = 3'd3,
    S_HALT    = 3'd4,
    S_RESTORE = 3'd5,
    S_LOCK    = 3'd6,
    S_SR_OUT  = 3'd7
  } seqState_t;

  localparam logic [1:0] MODE_RUN    = 2'b00;
  localparam logic [1:0] MODE_DIRECT = 2'b01;
  localparam logic [1:0] MODE_HALT   = 2'b10;

  typedef struct packed {
    logic save;
    logic pllOff;
    logic restore;
    logic waiting;
  } dpStrobe_t;

endpackage

// File: rtl/pms_ctrl.sv
module pms_ctrl
  import pms_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       suspendReq,
  input  logic       wakeHit,
  input  logic       srAck,
  input  logic       pllLock,
  output dpStrobe_t  strobe,
  output logic       clkSelPll,
  output logic       sysclkGate,
  output logic       srReq,
  output logic [1:0] modeOut
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_RUN;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      S_RUN:     if (suspendReq) nextState = S_SR_IN;
      S_SR_IN:   if (srAck)      nextState = S_SAVE;
      S_SAVE:                    nextState = S_PLL_OFF;
      S_PLL_OFF:                 nextState = S_HALT;
      S_HALT:    if (wakeHit)    nextState = S_RESTORE;
      S_RESTORE:                 nextState = S_LOCK;
      S_LOCK:    if (pllLock)    nextState = S_SR_OUT;
      S_SR_OUT:  if (!srAck)     nextState = S_RUN;
      default:                   nextState = S_RUN;
    endcase
  end

  always_comb begin
    strobe.save    = (state == S_SAVE);
    strobe.pllOff  = (state == S_PLL_OFF);
    strobe.restore = (state == S_RESTORE);
    strobe.waiting = ((state == S_SR_IN) && !srAck) ||
                     ((state == S_LOCK) && !pllLock) ||
                     ((state == S_SR_OUT) && srAck);
  end

  always_comb begin
    clkSelPll  = (state == S_RUN) || (state == S_SR_IN) || (state == S_SR_OUT);
    sysclkGate = (state == S_HALT);
    srReq      = !((state == S_RUN) || (state == S_SR_OUT));
    if (clkSelPll)       modeOut = MODE_RUN;
    else if (sysclkGate) modeOut = MODE_HALT;
    else                 modeOut = MODE_DIRECT;
  end

endmodule

// File: rtl/pms_dp.sv
module pms_dp
  import pms_pkg::*;
#(
  parameter int              CFG_W       = 16,
  parameter int              TMO_CYCLES  = 1024,
  parameter logic [CFG_W-1:0] PLL_RST_CFG = 16'h5A3C
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  output logic             pllEn,
  output logic [CFG_W-1:0] pllCfg,
  output logic             errTimeout,
  output logic             srClkAutoOff
);

  localparam int CW = $clog2(TMO_CYCLES + 1);

  logic [CFG_W-1:0] savedCfg;
  logic [CW-1:0]    waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pllEn    <= 1'b1;
      pllCfg   <= PLL_RST_CFG;
      savedCfg <= '0;
    end else begin
      if (strobe.save) savedCfg <= pllCfg;
      if (strobe.pllOff) begin
        pllEn  <= 1'b0;
        pllCfg <= '0;
      end else if (strobe.restore) begin
        pllEn  <= 1'b1;
        pllCfg <= savedCfg;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt    <= '0;
      errTimeout <= 1'b0;
    end else begin
      if (strobe.waiting) begin
        if (waitCnt != CW'(TMO_CYCLES)) waitCnt <= waitCnt + 1'b1;
        if (waitCnt == CW'(TMO_CYCLES - 1)) errTimeout <= 1'b1;
      end else begin
        waitCnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srClkAutoOff <= 1'b0;
    else       srClkAutoOff <= 1'b1;
  end

endmodule

// File: rtl/clk_pwr_seq.sv
module clk_pwr_seq
  import pms_pkg::*;
#(
  parameter int               WAKE_W      = 4,
  parameter int               CFG_W       = 16,
  parameter int               TMO_CYCLES  = 1024,
  parameter logic [CFG_W-1:0] PLL_RST_CFG = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              suspendReq,
  input  logic [WAKE_W-1:0] wakeEvt,
  input  logic [WAKE_W-1:0] wakeEn,
  input  logic              srAck,
  input  logic              pllLock,
  output logic              clkSelPll,
  output logic              pllEn,
  output logic [CFG_W-1:0]  pllCfg,
  output logic              sysclkGate,
  output logic              srReq,
  output logic              srClkAutoOff,
  output logic [1:0]        modeOut,
  output logic              errTimeout
);

  dpStrobe_t strobe;
  logic      wakeHit;

  assign wakeHit = |(wakeEvt & wakeEn);

  pms_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .suspendReq (suspendReq),
    .wakeHit    (wakeHit),
    .srAck      (srAck),
    .pllLock    (pllLock),
    .strobe     (strobe),
    .clkSelPll  (clkSelPll),
    .sysclkGate (sysclkGate),
    .srReq      (srReq),
    .modeOut    (modeOut)
  );

  pms_dp #(
    .CFG_W       (CFG_W),
    .TMO_CYCLES  (TMO_CYCLES),
    .PLL_RST_CFG (PLL_RST_CFG)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .pllEn        (pllEn),
    .pllCfg       (pllCfg),
    .errTimeout   (errTimeout),
    .srClkAutoOff (srClkAutoOff)
  );

endmodule

// File: rtl/clk_pwr_seq_chk.sv
module clk_pwr_seq_chk #(
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             srAck,
  input logic             pllLock,
  input logic             clkSelPll,
  input logic             pllEn,
  input logic [CFG_W-1:0] pllCfg,
  input logic             sysclkGate,
  input logic             srReq,
  input logic             srClkAutoOff,
  input logic [1:0]       modeOut,
  input logic             errTimeout
);

  p_leave_pll_after_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkSelPll) |-> $past(srAck));

  p_gate_only_halt_r5: assert property (@(posedge clk) disable iff (!rstN)
    sysclkGate |-> (modeOut == 2'b10) && !pllEn);

  p_lock_before_run_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkSelPll) |-> $past(pllLock));

  p_pll_moves_in_direct_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(pllEn) || !$stable(pllCfg)) |-> ($past(modeOut) == 2'b01));

  p_mode_legal_r9: assert property (@(posedge clk) disable iff (!rstN)
    modeOut != 2'b11);

  p_no_run_to_halt_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b10) |-> ($past(modeOut) != 2'b00));

  p_no_halt_to_run_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b00) |-> ($past(modeOut) != 2'b10));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(errTimeout) |-> errTimeout);

  p_auto_off_holds_r11: assert property (@(posedge clk) disable iff (!rstN)
    $past(srClkAutoOff) |-> srClkAutoOff);

  p_sr_outside_run_r12: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut != 2'b00) |-> srReq);

endmodule

bind clk_pwr_seq clk_pwr_seq_chk #(.CFG_W(CFG_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .srAck        (srAck),
  .pllLock      (pllLock),
  .clkSelPll    (clkSelPll),
  .pllEn        (pllEn),
  .pllCfg       (pllCfg),
  .sysclkGate   (sysclkGate),
  .srReq        (srReq),
  .srClkAutoOff (srClkAutoOff),
  .modeOut      (modeOut),
  .errTimeout   (errTimeout)
);

// File: tb/sim_clk_pwr_seq.sv
`timescale 1ns/1ps
module sim_clk_pwr_seq;

  localparam int          WAKE_W   = 4;
  localparam int          CFG_W    = 16;
  localparam int          TMO      = 24;
  localparam logic [15:0] RST_CFG  = 16'hC3A5;
  localparam int          SR_DLY   = 3;
  localparam int          LOCK_DLY = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic suspendReq = 1'b0;
  logic [WAKE_W-1:0] wakeEvt = '0;
  logic [WAKE_W-1:0] wakeEn = '0;
  logic srAck = 1'b0;
  logic pllLock = 1'b0;
  logic clkSelPll, pllEn, sysclkGate, srReq, srClkAutoOff, errTimeout;
  logic [CFG_W-1:0] pllCfg;
  logic [1:0] modeOut;

  always #4 clk = ~clk;

  clk_pwr_seq #(
    .WAKE_W(WAKE_W), .CFG_W(CFG_W), .TMO_CYCLES(TMO), .PLL_RST_CFG(RST_CFG)
  ) u0 (
    .clk(clk), .rstN(rstN), .suspendReq(suspendReq), .wakeEvt(wakeEvt),
    .wakeEn(wakeEn), .srAck(srAck), .pllLock(pllLock), .clkSelPll(clkSelPll),
    .pllEn(pllEn), .pllCfg(pllCfg), .sysclkGate(sysclkGate), .srReq(srReq),
    .srClkAutoOff(srClkAutoOff), .modeOut(modeOut), .errTimeout(errTimeout)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;
  bit dramDead = 0;
  bit started = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Memory side: acknowledge follows request after SR_DLY cycles
  int srCnt = 0;
  always @(negedge clk) begin
    if (dramDead || (srReq == srAck)) srCnt <= 0;
    else if (srCnt >= SR_DLY - 1) begin
      srAck <= srReq;
      srCnt <= 0;
    end else srCnt <= srCnt + 1;
  end

  // PLL side: lock LOCK_DLY cycles after enable, lost at once when disabled
  int lkCnt = 0;
  always @(negedge clk) begin
    if (!pllEn) begin
      pllLock <= 1'b0;
      lkCnt   <= 0;
    end else if (!pllLock) begin
      if (lkCnt >= LOCK_DLY - 1) pllLock <= 1'b1;
      else lkCnt <= lkCnt + 1;
    end
  end

  // Reference model: phase 0 idle, 1 await refresh, 2 save, 3 PLL off,
  // 4 halt, 5 restore, 6 await lock, 7 await refresh exit
  int mPhase = 0;
  bit mEn = 1;
  logic [CFG_W-1:0] mCfg = RST_CFG;
  logic [CFG_W-1:0] mSaved = '0;
  int mWait = 0;
  bit mErr = 0;
  bit mAuto = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mEn = 1; mCfg = RST_CFG; mSaved = '0;
      mWait = 0; mErr = 0; mAuto = 0;
    end else begin
      bit blocked;
      blocked = (mPhase == 1 && !srAck) || (mPhase == 6 && !pllLock) ||
                (mPhase == 7 && srAck);
      if (blocked) begin
        if (mWait == TMO - 1) mErr = 1;
        if (mWait < TMO) mWait++;
      end else mWait = 0;
      mAuto = 1;
      case (mPhase)
        0: if (suspendReq) mPhase = 1;
        1: if (srAck) mPhase = 2;
        2: begin mSaved = mCfg; mPhase = 3; end
        3: begin mEn = 0; mCfg = '0; mPhase = 4; end
        4: if ((wakeEvt & wakeEn) != 0) mPhase = 5;
        5: begin mEn = 1; mCfg = mSaved; mPhase = 6; end
        6: if (pllLock) mPhase = 7;
        default: if (!srAck) mPhase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      int eMode;
      bit eSel, eGate, eSr;
      eSel  = (mPhase == 0 || mPhase == 1 || mPhase == 7);
      eGate = (mPhase == 4);
      eSr   = (mPhase >= 1 && mPhase <= 6);
      eMode = eSel ? 0 : (eGate ? 2 : 1);
      check(modeOut == 2'(eMode), "R3 modeOut", modeOut, eMode);
      check(clkSelPll == eSel, "R3 clkSelPll", clkSelPll, eSel);
      check(pllEn == mEn, "R4 pllEn", pllEn, mEn);
      check(pllCfg == mCfg, "R6 pllCfg", pllCfg, mCfg);
      check(sysclkGate == eGate, "R5 sysclkGate", sysclkGate, eGate);
      check(srReq == eSr, "R12 srReq", srReq, eSr);
      check(errTimeout == mErr, "R10 errTimeout", errTimeout, mErr);
      check(srClkAutoOff == mAuto, "R11 srClkAutoOff", srClkAutoOff, mAuto);
    end
  end

  task automatic waitMode(input logic [1:0] m);
    for (int i = 0; i < 200; i++) begin
      if (modeOut == m) break;
      @(negedge clk);
    end
  endtask

  task automatic roundTrip(input logic [WAKE_W-1:0] wline);
    suspendReq = 1'b1;
    @(negedge clk);
    suspendReq = 1'b0;
    check(srReq == 1'b1 && modeOut == 2'b00, "R3 req before leaving PLL", modeOut, 0);
    waitMode(2'b10);
    check(sysclkGate && !pllEn && pllCfg == 0, "R5 halt entered", {sysclkGate, pllEn}, 2);
    repeat (3) @(negedge clk);
    wakeEn = wline; wakeEvt = wline;
    @(negedge clk);
    wakeEvt = '0;
    check(modeOut == 2'b01 && !sysclkGate, "R6 wake to direct-run", modeOut, 1);
    @(negedge clk);
    check(pllEn && pllCfg == RST_CFG, "R6 PLL restored", pllCfg, RST_CFG);
    waitMode(2'b00);
    check(clkSelPll && !srReq && pllLock, "R7 run after lock", {clkSelPll, srReq}, 2);
    repeat (SR_DLY + 3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 20000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(modeOut == 2'b00 && clkSelPll && pllEn, "R1 reset mode", modeOut, 0);
    check(pllCfg == RST_CFG, "R1 reset cfg", pllCfg, RST_CFG);
    check(!srReq && !sysclkGate && !errTimeout && !srClkAutoOff, "R1 reset flags",
          {srReq, sysclkGate, errTimeout, srClkAutoOff}, 0);
    started = 1;
    rstN = 1'b1;
    @(negedge clk);
    check(srClkAutoOff == 1'b1, "R11 auto-off set", srClkAutoOff, 1);
    repeat (LOCK_DLY + 2) @(negedge clk);

    // R2: wake while running is ignored
    wakeEn = '1; wakeEvt = 4'b0101;
    repeat (3) @(negedge clk);
    wakeEvt = '0;
    check(modeOut == 2'b00 && !srReq, "R2 wake ignored in run", modeOut, 0);

    // Full suspend with probes inside halt
    suspendReq = 1'b1;
    @(negedge clk);
    suspendReq = 1'b0;
    waitMode(2'b10);
    check(pllCfg == 0 && !pllEn, "R8 PLL off in halt", pllCfg, 0);
    suspendReq = 1'b1;
    @(negedge clk);
    suspendReq = 1'b0;
    @(negedge clk);
    check(modeOut == 2'b10, "R2 suspend ignored in halt", modeOut, 2);
    wakeEn = 4'b0010; wakeEvt = 4'b1101;
    repeat (3) @(negedge clk);
    check(modeOut == 2'b10 && sysclkGate, "R5 masked wake ignored", modeOut, 2);
    wakeEvt = 4'b0010;
    @(negedge clk);
    wakeEvt = '0;
    check(modeOut == 2'b01, "R6 enabled wake", modeOut, 1);
    @(negedge clk);
    check(pllCfg == RST_CFG && pllEn, "R6 cfg restored", pllCfg, RST_CFG);
    waitMode(2'b00);
    check(clkSelPll && !srReq, "R7 back to run", clkSelPll, 1);
    check(modeOut != 2'b11, "R9 legal mode", modeOut, 0);
    repeat (SR_DLY + 3) @(negedge clk);

    roundTrip(4'b1000);

    // R10: refresh acknowledge withheld beyond the timeout
    dramDead = 1;
    suspendReq = 1'b1;
    @(negedge clk);
    suspendReq = 1'b0;
    repeat (TMO + 3) @(negedge clk);
    check(errTimeout == 1'b1, "R10 timeout raised", errTimeout, 1);
    check(modeOut == 2'b00 && srReq, "R10 still waiting", modeOut, 0);
    dramDead = 0;
    waitMode(2'b10);
    wakeEn = 4'b0001; wakeEvt = 4'b0001;
    @(negedge clk);
    wakeEvt = '0;
    waitMode(2'b00);
    repeat (SR_DLY + 3) @(negedge clk);
    check(errTimeout == 1'b1 && !srReq, "R10 sticky after recovery", errTimeout, 1);

    rstN = 1'b0;
    @(negedge clk);
    check(errTimeout == 1'b0 && pllCfg == RST_CFG, "R1 reset clears error", errTimeout, 0);
    rstN = 1'b1;
    repeat (LOCK_DLY + 2) @(negedge clk);
    roundTrip(4'b0100);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule